// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Timing

This block carries 36-bit words from one clock domain to another. A producer on the write clock pushes words through a valid/ready port gated by a chip select. A consumer on the read clock pulls them back out in arrival order. The two clocks free-run and may be unrelated or tied to the same source. Each pointer crosses to the other domain as gray code through a two-flop synchronizer. As a result, every flag that depends on the far side is conservative and settles a few destination cycles late.

A static mode pin selects one of two read behaviours. In standard mode the consumer raises `out_ready` while words are present, and each accepted request returns one word, marked by a one-cycle `out_valid`, on the next read clock. In that mode `rd_flag` is an empty flag and `wr_flag` is a full flag. In fall-through mode the head word is prefetched into an output stage without any request. `out_valid` (mirrored on `rd_flag`) then means "word on the bus", and `out_ready` pops it. In that mode `wr_flag` reads as space-available.

Back-pressure rules:
- A write takes effect only on a write-clock edge where `in_valid`, `in_cs` and `in_ready` are all high.
- A read request is acted on only while a word is available.

Almost-full and almost-empty thresholds come from a two-bit select that is sampled while reset is held low. Three select codes give preset margins. The fourth takes the margin from the low data-input bits.

Top module: `dual_clock_fifo`

## Requirements
- R1: Words leave in the order they were accepted, all 36 bits unchanged. Storage holds DEPTH words, with a default of 2048.
- R2: A write is accepted on a write-clock edge only when `in_valid`, `in_cs` and `in_ready` are all 1. `in_ready` is 0 exactly when DEPTH words are stored.
- R3: A write attempted while `in_ready` is 0 is ignored. It is not counted, it changes no stored word, and it does not change the order of the words that are read out.
- R4: In standard mode (`fwft_mode`=0), a request with `out_ready`=1 while a word is held gives that word on `out_data`, with `out_valid`=1 for exactly one read cycle after the request edge. Requests made while empty give no `out_valid`. `rd_flag`=1 means empty.
- R5: In fall-through mode (`fwft_mode`=1), the head word appears on `out_data` with `out_valid`=`rd_flag`=1 without any request. It stays stable until a cycle with `out_ready`=1 pops it, after which the next word (if any) is shown on the following cycle.
- R6: `wr_flag` is the full flag (1 when DEPTH words are held) in standard mode, and the space-available flag (1 when a write can be taken) in fall-through mode. In fall-through mode DEPTH+1 words fit, because one word waits in the output stage.
- R7: `almost_full`=1 when the write-side word count is at least DEPTH minus the programmed offset.
- R8: `almost_empty`=1 when the read-side word count is at most the programmed offset. In fall-through mode the word in the output stage counts toward this.
- R9: The offset is loaded on clock edges while `rst_n`=0, using `ofs_sel`: 01 gives 8, 10 gives 16, 11 gives 64, and 00 takes `in_data[10:0]` (for the default depth).
- R10: After reset, the block is empty with no output word: `out_valid`=0, `in_ready`=1, `almost_empty`=1, `almost_full`=0. `rd_flag` is 1 in standard mode and 0 in fall-through mode. `wr_flag` is 0 in standard mode and 1 in fall-through mode.
- R11: Writing and reading on the same clock edge, with both clocks from one source, loses and duplicates no word.
- R12: After a write into an empty block, the empty indication clears no earlier than one and no later than three read-clock edges after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides; offsets are loaded while low |
| fwft_mode | input | 1 | Static: 0 standard timing, 1 fall-through timing |
| ofs_sel | input | 2 | Static: threshold offset select |
| in_valid | input | 1 | Write request |
| in_cs | input | 1 | Write chip select |
| in_data | input | 36 | Write data; low bits give the user offset during reset |
| in_ready | output | 1 | Space available for a write |
| wr_flag | output | 1 | Full (standard) or space-available (fall-through) |
| almost_full | output | 1 | Write-side threshold flag |
| out_ready | input | 1 | Read request (standard) or pop (fall-through) |
| out_valid | output | 1 | Word present on `out_data` |
| out_data | output | 36 | Read data |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Read-side threshold flag |

## Verification
A corrupted write or read pointer appears at the ports in one of two ways: the drained word sequence skips, repeats or reorders, or it comes up one word short or long. This shows from the first affected word onward. A fault in a synchronizer or in the gray-to-binary conversion shows as an empty or full flag that never clears, or that clears too early. The latency measurement and the fill-count checks catch this within a few cycles of the write that should have moved the flag. A mistaken offset decode moves the almost flags by a whole step, which is visible at the exact word count on either side of each threshold.

// File: rtl/xf_pkg.sv
package xf_pkg;

  // Threshold margin chosen by the static select; code 00 uses the user value.
  function automatic logic [15:0] xf_ofs(input logic [1:0] sel, input logic [15:0] user);
    case (sel)
      2'b01:   return 16'd8;
      2'b10:   return 16'd16;
      2'b11:   return 16'd64;
      default: return user;
    endcase
  endfunction

endpackage

// File: rtl/xf_gray_sync.sv
module xf_gray_sync #(
  parameter int N = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] gray_in,
  output logic [N-1:0] bin_out
);
  logic [N-1:0] stg1, stg2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1 <= '0;
      stg2 <= '0;
    end else begin
      stg1 <= gray_in;
      stg2 <= stg1;
    end
  end

  always_comb begin
    logic [N-1:0] acc;
    acc[N-1] = stg2[N-1];
    for (int i = N - 2; i >= 0; i--) acc[i] = acc[i+1] ^ stg2[i];
    bin_out = acc;
  end
endmodule

// File: rtl/xf_wr_ctl.sv
module xf_wr_ctl
  import xf_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic [1:0]    ofs_sel,
  input  logic [AW-1:0] ofs_user,
  input  logic          in_valid,
  input  logic          in_cs,
  input  logic [PW-1:0] rptr_sync,
  output logic [PW-1:0] wptr_bin,
  output logic [PW-1:0] wptr_gray,
  output logic [PW-1:0] wr_level,
  output logic          wr_en,
  output logic          in_ready,
  output logic          wr_flag,
  output logic          almost_full
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [AW-1:0] ofs;
  logic          full;
  logic [PW-1:0] wptr_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) ofs <= AW'(xf_ofs(ofs_sel, 16'(ofs_user)));
  end

  assign wr_level = wptr_bin - rptr_sync;
  assign full     = (wr_level == DEPTH_P);
  assign in_ready = ~full;
  assign wr_en    = in_valid & in_cs & ~full;
  assign wptr_nxt = wptr_bin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
    end else if (wr_en) begin
      wptr_bin  <= wptr_nxt;
      wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  assign wr_flag     = fwft_mode ? ~full : full;
  assign almost_full = (wr_level >= (DEPTH_P - {1'b0, ofs}));
endmodule

// File: rtl/xf_rd_ctl.sv
module xf_rd_ctl
  import xf_pkg::*;
#(
  parameter int W = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic [1:0]    ofs_sel,
  input  logic [AW-1:0] ofs_user,
  input  logic [PW-1:0] wptr_sync,
  input  logic          out_ready,
  input  logic [W-1:0]  mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rptr_bin,
  output logic [PW-1:0] rptr_gray,
  output logic          mem_empty,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          rd_flag,
  output logic          almost_empty
);
  logic [AW-1:0] ofs;
  logic [PW-1:0] mem_level, all_level, rptr_nxt;
  logic          stage_v, pop;

  always_ff @(posedge clk) begin
    if (!rst_n) ofs <= AW'(xf_ofs(ofs_sel, 16'(ofs_user)));
  end

  assign mem_level = wptr_sync - rptr_bin;
  assign mem_empty = (mem_level == '0);
  assign pop       = ~mem_empty & (fwft_mode ? (~stage_v | out_ready) : out_ready);
  assign rptr_nxt  = rptr_bin + PW'(1);
  assign raddr     = rptr_bin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      out_data  <= '0;
      stage_v   <= 1'b0;
    end else begin
      if (pop) begin
        rptr_bin  <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
        out_data  <= mem_rdata;
      end
      if (!fwft_mode)  stage_v <= pop;
      else if (pop)    stage_v <= 1'b1;
      else if (out_ready) stage_v <= 1'b0;
    end
  end

  assign out_valid    = stage_v;
  assign rd_flag      = fwft_mode ? stage_v : mem_empty;
  assign all_level    = mem_level + PW'(fwft_mode & stage_v);
  assign almost_empty = (all_level <= {1'b0, ofs});
endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
  parameter int W = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic         wr_clk,
  input  logic         rd_clk,
  input  logic         rst_n,
  input  logic         fwft_mode,
  input  logic [1:0]   ofs_sel,
  input  logic         in_valid,
  input  logic         in_cs,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         wr_flag,
  output logic         almost_full,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         rd_flag,
  output logic         almost_empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_bin, wptr_gray, rptr_bin, rptr_gray;
  logic [PW-1:0] wptr_at_rd, rptr_at_wr, wr_level;
  logic [AW-1:0] raddr;
  logic [W-1:0]  mem_rdata;
  logic          wr_en, mem_empty;

  xf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .ofs_sel(ofs_sel),
    .ofs_user(in_data[AW-1:0]), .in_valid(in_valid), .in_cs(in_cs),
    .rptr_sync(rptr_at_wr), .wptr_bin(wptr_bin), .wptr_gray(wptr_gray),
    .wr_level(wr_level), .wr_en(wr_en), .in_ready(in_ready),
    .wr_flag(wr_flag), .almost_full(almost_full)
  );

  xf_gray_sync #(.N(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wptr_gray), .bin_out(wptr_at_rd)
  );

  xf_gray_sync #(.N(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rptr_gray), .bin_out(rptr_at_wr)
  );

  xf_rd_ctl #(.W(W), .DEPTH(DEPTH)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode), .ofs_sel(ofs_sel),
    .ofs_user(in_data[AW-1:0]), .wptr_sync(wptr_at_rd), .out_ready(out_ready),
    .mem_rdata(mem_rdata), .raddr(raddr), .rptr_bin(rptr_bin),
    .rptr_gray(rptr_gray), .mem_empty(mem_empty), .out_valid(out_valid),
    .out_data(out_data), .rd_flag(rd_flag), .almost_empty(almost_empty)
  );

  always_ff @(posedge wr_clk) begin
    if (wr_en) mem[wptr_bin[AW-1:0]] <= in_data;
  end

  assign mem_rdata = mem[raddr];
endmodule

// File: rtl/xf_checker.sv
module xf_checker #(
  parameter int W = 36,
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          fwft_mode,
  input logic          in_valid,
  input logic          in_cs,
  input logic          in_ready,
  input logic          out_ready,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wr_level,
  input logic          rd_empty
);
  AST_ACCEPT_ADVANCES: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (in_valid && in_cs && in_ready) |=> (wptr == $past(wptr) + PW'(1))); // R2

  AST_FULL_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (in_valid && in_cs && !in_ready) |=> $stable(wptr)); // R3

  AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (wr_level <= PW'(DEPTH))); // R3

  AST_EMPTY_NO_POP: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_empty |=> $stable(rptr)); // R4

  AST_STD_PULSE_REQ: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && out_valid) |-> $past(out_ready)); // R4

  AST_FWFT_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (fwft_mode && out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R5
endmodule

bind dual_clock_fifo xf_checker #(.W(W), .DEPTH(DEPTH)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
  .in_valid(in_valid), .in_cs(in_cs), .in_ready(in_ready),
  .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
  .wptr(wptr_bin), .rptr(rptr_bin), .wr_level(wr_level), .rd_empty(mem_empty)
);

// File: tb/dual_clock_fifo_test.sv
module dual_clock_fifo_test;
  localparam int W = 36;
  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n = 1'b1, fwft = 1'b0, in_valid = 1'b0, in_cs = 1'b0, out_ready = 1'b0;
  logic [1:0]   ofs_sel = 2'b01;
  logic [W-1:0] in_data = '0;
  logic         in_ready, wr_flag, almost_full, out_valid, rd_flag, almost_empty;
  logic [W-1:0] out_data;

  dual_clock_fifo #(.W(W), .DEPTH(DEPTH)) uut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_mode(fwft), .ofs_sel(ofs_sel),
    .in_valid(in_valid), .in_cs(in_cs), .in_data(in_data), .in_ready(in_ready),
    .wr_flag(wr_flag), .almost_full(almost_full), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data), .rd_flag(rd_flag),
    .almost_empty(almost_empty)
  );

  int n_run = 0, n_fail = 0, seq = 0;
  logic [W-1:0] q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit fw, input logic [1:0] sel, input logic [W-1:0] user);
    @(negedge clk);
    rst_n = 1'b0; fwft = fw; ofs_sel = sel; in_data = user;
    in_valid = 1'b0; in_cs = 1'b0; out_ready = 1'b0;
    q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1'b1; in_data = '0;
    @(negedge clk);
  endtask

  task automatic push_n(input int n, output int acc);
    acc = 0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_cs = 1'b1;
      in_data = {4'h5, 32'(seq)};
      seq++;
      if (in_ready) begin acc++; q.push_back(in_data); end
      @(negedge clk);
    end
    in_valid = 1'b0; in_cs = 1'b0;
  endtask

  task automatic drain_n(input int n, input string req);
    int got = 0, bad = 0, guard = 0;
    logic [W-1:0] la = '0, le = '0;
    out_ready = 1'b1;
    while (got < n && guard < 10 * n + 50) begin
      if (out_valid) begin
        logic [W-1:0] e;
        e = (q.size() > 0) ? q.pop_front() : '1;
        if (out_data !== e && bad == 0) begin la = out_data; le = e; end
        if (out_data !== e) bad++;
        got++;
      end
      @(negedge clk);
      guard++;
    end
    out_ready = 1'b0;
    chk(bad == 0 && got == n, req, "drained sequence", (bad != 0) ? la : W'(got), (bad != 0) ? le : W'(n));
  endtask

  // R10 R4 R12 R1: reset state, empty requests, flag latency, single reads
  task automatic t_std_basic();
    int a, lat, seen;
    do_reset(1'b0, 2'b01, '0);
    chk(rd_flag == 1'b1 && wr_flag == 1'b0 && in_ready == 1'b1, "R10", "std reset flags",
        W'({rd_flag, wr_flag, in_ready}), W'(3'b101));
    chk(out_valid == 1'b0 && almost_empty && !almost_full, "R10", "std reset status",
        W'({out_valid, almost_empty, almost_full}), W'(3'b010));
    seen = 0;
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin @(negedge clk); if (out_valid) seen++; end
    out_ready = 1'b0;
    chk(seen == 0, "R4", "request while empty", W'(seen), W'(0));
    push_n(1, a);
    lat = 0;
    while (rd_flag && lat < 10) begin @(negedge clk); lat++; end
    chk(lat >= 1 && lat <= 3, "R12", "empty clear latency", W'(lat), W'(2));
    push_n(2, a);
    repeat (4) @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid && out_data == q[0], "R4", "single read word", out_data, q[0]);
    void'(q.pop_front());
    @(negedge clk);
    chk(!out_valid, "R4", "valid is one cycle", W'(out_valid), W'(0));
    drain_n(2, "R1");
    repeat (4) @(negedge clk);
    chk(rd_flag == 1'b1, "R4", "empty after drain", W'(rd_flag), W'(1));
  endtask

  // R2: chip select low blocks writes
  task automatic t_cs();
    do_reset(1'b0, 2'b01, '0);
    in_valid = 1'b1; in_cs = 1'b0; in_data = 36'hABCDE;
    repeat (4) @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(rd_flag == 1'b1 && almost_empty, "R2", "cs low ignored", W'(rd_flag), W'(1));
  endtask

  // R8 R7 R6 R3 R1: thresholds, full, writes while full, full drain
  task automatic t_fill_std();
    int a;
    do_reset(1'b0, 2'b01, '0);
    push_n(8, a);
    repeat (4) @(negedge clk);
    chk(almost_empty == 1'b1, "R8", "ae at 8 words", W'(almost_empty), W'(1));
    push_n(1, a);
    repeat (4) @(negedge clk);
    chk(almost_empty == 1'b0, "R8", "ae at 9 words", W'(almost_empty), W'(0));
    push_n(DEPTH - 9 - 9, a);
    chk(almost_full == 1'b0, "R7", "af at DEPTH-9", W'(almost_full), W'(0));
    push_n(1, a);
    chk(almost_full == 1'b1, "R7", "af at DEPTH-8", W'(almost_full), W'(1));
    push_n(8, a);
    chk(wr_flag == 1'b1 && in_ready == 1'b0, "R6", "std full flag",
        W'({wr_flag, in_ready}), W'(2'b10));
    push_n(3, a);
    chk(a == 0, "R3", "writes while full accepted", W'(a), W'(0));
    chk(q.size() == DEPTH, "R2", "accepted count", W'(q.size()), W'(DEPTH));
    drain_n(DEPTH, "R3");
    repeat (5) @(negedge clk);
    chk(rd_flag == 1'b1 && !out_valid, "R3", "no extra words", W'({rd_flag, out_valid}), W'(2'b10));
  endtask

  // R9: offset select codes
  task automatic t_ofs(input logic [1:0] sel, input logic [W-1:0] user, input int thr);
    int a;
    do_reset(1'b0, sel, user);
    push_n(thr, a);
    repeat (4) @(negedge clk);
    chk(almost_empty == 1'b1, "R9", $sformatf("ae at %0d sel %0d", thr, sel), W'(almost_empty), W'(1));
    push_n(1, a);
    repeat (4) @(negedge clk);
    chk(almost_empty == 1'b0, "R9", $sformatf("ae at %0d sel %0d", thr + 1, sel), W'(almost_empty), W'(0));
  endtask

  // R5 R6 R10: fall-through timing
  task automatic t_fwft();
    int a;
    do_reset(1'b1, 2'b01, '0);
    chk(rd_flag == 1'b0 && wr_flag == 1'b1 && !out_valid, "R10", "fwft reset flags",
        W'({rd_flag, wr_flag, out_valid}), W'(3'b010));
    push_n(3, a);
    repeat (5) @(negedge clk);
    chk(out_valid && rd_flag && out_data == q[0], "R5", "first word unrequested", out_data, q[0]);
    repeat (3) @(negedge clk);
    chk(out_valid && out_data == q[0], "R5", "head held without pop", out_data, q[0]);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    void'(q.pop_front());
    chk(out_valid && out_data == q[0], "R5", "next word after pop", out_data, q[0]);
    drain_n(2, "R5");
    @(negedge clk);
    chk(!out_valid && !rd_flag, "R5", "not ready when empty", W'({out_valid, rd_flag}), W'(0));
    do_reset(1'b1, 2'b01, '0);
    push_n(DEPTH + 5, a);
    chk(a == DEPTH + 1, "R6", "fwft capacity", W'(a), W'(DEPTH + 1));
    chk(wr_flag == 1'b0 && in_ready == 1'b0, "R6", "fwft input not ready", W'(wr_flag), W'(0));
  endtask

  // R11 R1: simultaneous write and read on shared clock
  task automatic t_concurrent();
    int a;
    do_reset(1'b0, 2'b01, '0);
    fork
      push_n(50, a);
      drain_n(50, "R11");
    join
    repeat (4) @(negedge clk);
    chk(rd_flag == 1'b1 && a == 50, "R11", "all accepted and empty", W'(a), W'(50));
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_std_basic();
    t_cs();
    t_fill_std();
    t_ofs(2'b10, '0, 16);
    t_ofs(2'b11, '0, 64);
    t_ofs(2'b00, 36'd20, 20);
    t_fwft();
    t_concurrent();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule